// File: doc/BRIEF.md
# UART hardware flow control unit

This block sits beside a UART's receive FIFO, transmitter and host register bus and carries out automatic modem-line flow control. It drives the RTS output from the receive FIFO fill level, using two host-programmed thresholds. One threshold raises RTS and the other drops it, and RTS holds its state in the band between them. It synchronizes the incoming CTS line and asks the transmitter to pause. A pause only begins between characters, so a frame that is already being sent always finishes.

The block also compares every received byte with a programmable special character. A match raises a sticky interrupt flag that a read of the interrupt identification register clears. The matching byte still goes to the FIFO. This block never blocks FIFO writes. It also holds the enable for the protected high fields of the neighbouring IER, FCR and MCR registers. Host writes to those fields produce a one-cycle write strobe only while that enable is set.

Top module: `uart_hwflow_ctrl`

## Requirements
- R1: After synchronous reset, `rts_pin`, `tx_stop`, `spchar_irq` and `prot_we` are 0. Every feature enable (feature register bits 7..4) is 0.
- R2: Host address 0 is the feature register, and bit 6 of it enables RTS control. While bit 6 is 0, `rts_pin` is LOW from the cycle after the register update.
- R3: Host address 1 is the trigger register. Its bits [3:0] times 4 give the halt level in bytes. With RTS control on, a level at or above the halt level makes `rts_pin` HIGH one cycle later. If a level meets both the halt and the resume condition, halt wins.
- R4: Bits [7:4] of the trigger register times 4 give the resume level. A level at or below the resume level, and below the halt level, makes `rts_pin` LOW one cycle later.
- R5: A level strictly between the resume and halt levels leaves `rts_pin` unchanged.
- R6: Feature bit 7 enables CTS control. `cts_pin` passes through two flops. When CTS is HIGH, `tx_stop` rises at the first clock edge where `tx_char_boundary` is HIGH, and not earlier than the third edge after CTS changes.
- R7: `tx_stop` never rises while `tx_char_boundary` is LOW. It falls on the edge after the synchronized CTS goes LOW or CTS control is disabled, whatever the boundary input does.
- R8: Host address 2 holds the special character, and feature bit 5 enables detection. A `rx_valid` byte equal to it sets `spchar_irq` one cycle later. A mismatching byte, or any byte while detection is off, does not set it.
- R9: `spchar_irq` stays set until a cycle with `host_iir_rd` HIGH clears it. A match in that same cycle keeps it set.
- R10: Feature bit 4 enables the protected fields. A host write to address 3 (IER), 4 (FCR) or 5 (MCR) gives `prot_we` bit 0, 1 or 2 for one cycle, with `prot_wdata` equal to the written byte. While bit 4 is 0, such writes leave `prot_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin | input | 1 | Asynchronous clear-to-send line, HIGH means stop |
| tx_char_boundary | input | 1 | HIGH when the transmitter is between characters |
| rx_level | input | 7 | Receive FIFO fill level in bytes |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Strobe for `rx_byte` |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_iir_rd | input | 1 | Host read of the interrupt identification register |
| rts_pin | output | 1 | Request-to-send line, HIGH means halt the far end |
| tx_stop | output | 1 | Pause request to the transmitter |
| spchar_irq | output | 1 | Special-character flag (interrupt identification bit 4) |
| prot_we | output | 3 | One-hot write strobe for the IER, FCR and MCR protected fields |
| prot_wdata | output | 8 | Data that goes with `prot_we` |

## Verification
The bench moves the FIFO level in both directions across the two thresholds. It includes values exactly on each threshold, where a comparison written as strict instead of inclusive would put the RTS edge one level late. It also programs a halt level at or below the resume level, where a design that checks resume first would leave RTS stuck LOW. CTS is raised with the character boundary held LOW, to catch a design that cuts a frame short. The bench then counts the synchronizer edges, to catch a missing or extra stage. The special-character flag is struck by a match and a host read in the same cycle, where a clear-wins design loses the event. Writes to the protected fields are made with the enable clear, where a leaky gate would strobe a field that must stay unchanged.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;
  localparam int HADDR_W = 3;
  localparam logic [HADDR_W-1:0] A_FEAT  = 3'd0;
  localparam logic [HADDR_W-1:0] A_TRIG  = 3'd1;
  localparam logic [HADDR_W-1:0] A_XOFF2 = 3'd2;
  localparam logic [HADDR_W-1:0] A_IER   = 3'd3;
  localparam logic [HADDR_W-1:0] A_FCR   = 3'd4;
  localparam logic [HADDR_W-1:0] A_MCR   = 3'd5;
  localparam int NPROT = 3;

  typedef struct packed {
    logic cts_en;
    logic rts_en;
    logic spc_en;
    logic enh_en;
  } feat_t;
endpackage

// File: rtl/hwflow_regs.sv
module hwflow_regs
  import hwflow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic [HADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output feat_t               feat,
  output logic [DATA_W-1:0]   trig,
  output logic [DATA_W-1:0]   xoff2,
  output logic [NPROT-1:0]    prot_we,
  output logic [DATA_W-1:0]   prot_wdata
);
  logic [NPROT-1:0] prot_hit;

  generate
    for (genvar g = 0; g < NPROT; g++) begin : g_prot
      assign prot_hit[g] = host_wr && (host_addr == A_IER + HADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      feat  <= '0;
      trig  <= '0;
      xoff2 <= '0;
    end else if (host_wr) begin
      case (host_addr)
        A_FEAT:  feat  <= feat_t'(host_wdata[DATA_W-1 -: 4]);
        A_TRIG:  trig  <= host_wdata;
        A_XOFF2: xoff2 <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_we    <= '0;
      prot_wdata <= '0;
    end else begin
      prot_we    <= feat.enh_en ? prot_hit : '0;
      prot_wdata <= host_wdata;
    end
  end

  // R10: a gated write never strobes a protected field
  assert_prot_block_R10: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !feat.enh_en && host_addr >= A_IER && host_addr <= A_MCR) |=> (prot_we == '0));
  // R10: at most one protected field per cycle
  assert_prot_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prot_we));
endmodule

// File: rtl/hwflow_rts.sv
module hwflow_rts #(
  parameter int LVL_W     = 7,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rts_en,
  input  logic [2*THR_W-1:0] trig,
  input  logic [LVL_W-1:0]   rx_level,
  output logic               rts_pin
);
  logic [LVL_W-1:0] halt_lvl;
  logic [LVL_W-1:0] resume_lvl;
  logic             at_halt;
  logic             at_resume;

  assign halt_lvl   = LVL_W'(trig[THR_W-1:0]) << THR_SHIFT;
  assign resume_lvl = LVL_W'(trig[2*THR_W-1:THR_W]) << THR_SHIFT;
  assign at_halt    = rx_level >= halt_lvl;
  assign at_resume  = rx_level <= resume_lvl;

  always_ff @(posedge clk) begin
    if (rst || !rts_en)  rts_pin <= 1'b0;
    else if (at_halt)    rts_pin <= 1'b1;
    else if (at_resume)  rts_pin <= 1'b0;
  end

  assert_rts_off_R2: assert property (@(posedge clk) disable iff (rst)
    !rts_en |=> !rts_pin);
  assert_rts_halt_R3: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_level >= halt_lvl) |=> rts_pin);
  assert_rts_resume_R4: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_level <= resume_lvl && rx_level < halt_lvl) |=> !rts_pin);
  assert_rts_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rts_en && rx_level > resume_lvl && rx_level < halt_lvl) |=> $stable(rts_pin));
endmodule

// File: rtl/hwflow_cts.sv
module hwflow_cts #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_en,
  input  logic cts_pin,
  input  logic tx_char_boundary,
  output logic tx_stop
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cts_s;
  logic                   stop_req;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= rst ? '0 : cts_pin;
    end else begin : g_chain
      always_ff @(posedge clk)
        sync_q <= rst ? '0 : {sync_q[SYNC_STAGES-2:0], cts_pin};
    end
  endgenerate

  assign cts_s    = sync_q[SYNC_STAGES-1];
  assign stop_req = cts_en && cts_s;

  always_ff @(posedge clk) begin
    if (rst || !stop_req)       tx_stop <= 1'b0;
    else if (tx_char_boundary)  tx_stop <= 1'b1;
  end

  assert_stop_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_stop) |-> $past(tx_char_boundary));
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> !tx_stop);
  assert_stop_take_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_req && tx_char_boundary) |=> tx_stop);
endmodule

// File: rtl/hwflow_spchar.sv
module hwflow_spchar #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spc_en,
  input  logic [DATA_W-1:0] xoff2,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              host_iir_rd,
  output logic              spchar_irq
);
  logic hit;

  assign hit = rx_valid && spc_en && (rx_byte == xoff2);

  always_ff @(posedge clk) begin
    if (rst)               spchar_irq <= 1'b0;
    else if (hit)          spchar_irq <= 1'b1;
    else if (host_iir_rd)  spchar_irq <= 1'b0;
  end

  assert_spc_set_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && spc_en && rx_byte == xoff2) |=> spchar_irq);
  assert_spc_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (spchar_irq && !host_iir_rd) |=> spchar_irq);
  assert_spc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (host_iir_rd && !(rx_valid && spc_en && rx_byte == xoff2)) |=> !spchar_irq);
endmodule

// File: rtl/uart_hwflow_ctrl.sv
module uart_hwflow_ctrl
  import hwflow_pkg::*;
#(
  parameter int FIFO_DEPTH  = 64,
  parameter int DATA_W      = 8,
  parameter int THR_SHIFT   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int THR_W      = DATA_W / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cts_pin,
  input  logic               tx_char_boundary,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [DATA_W-1:0]  rx_byte,
  input  logic               rx_valid,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic               host_iir_rd,
  output logic               rts_pin,
  output logic               tx_stop,
  output logic               spchar_irq,
  output logic [NPROT-1:0]   prot_we,
  output logic [DATA_W-1:0]  prot_wdata
);
  feat_t             feat;
  logic [DATA_W-1:0] trig;
  logic [DATA_W-1:0] xoff2;

  hwflow_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .feat(feat), .trig(trig), .xoff2(xoff2),
    .prot_we(prot_we), .prot_wdata(prot_wdata)
  );

  hwflow_rts #(.LVL_W(LVL_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)) u_rts (
    .clk(clk), .rst(rst), .rts_en(feat.rts_en), .trig(trig),
    .rx_level(rx_level), .rts_pin(rts_pin)
  );

  hwflow_cts #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst(rst), .cts_en(feat.cts_en), .cts_pin(cts_pin),
    .tx_char_boundary(tx_char_boundary), .tx_stop(tx_stop)
  );

  hwflow_spchar #(.DATA_W(DATA_W)) u_spc (
    .clk(clk), .rst(rst), .spc_en(feat.spc_en), .xoff2(xoff2),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .host_iir_rd(host_iir_rd),
    .spchar_irq(spchar_irq)
  );

  // R1: outputs quiet on the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rts_pin && !tx_stop && !spchar_irq && prot_we == '0));
endmodule

// File: tb/uart_hwflow_ctrl_bench.sv
module uart_hwflow_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cts_pin = 1'b0;
  logic       tx_char_boundary = 1'b0;
  logic [6:0] rx_level = '0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_iir_rd = 1'b0;
  logic       rts_pin, tx_stop, spchar_irq;
  logic [2:0] prot_we;
  logic [7:0] prot_wdata;

  int vectors = 0;
  int fails = 0;
  logic       m_rts = 1'b0;
  logic       m_flag = 1'b0;
  logic [7:0] m_trig = '0;

  always #5 clk = ~clk;

  uart_hwflow_ctrl u_uart_hwflow_ctrl (
    .clk(clk), .rst(rst), .cts_pin(cts_pin), .tx_char_boundary(tx_char_boundary),
    .rx_level(rx_level), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_iir_rd(host_iir_rd), .rts_pin(rts_pin), .tx_stop(tx_stop),
    .spchar_irq(spchar_irq), .prot_we(prot_we), .prot_wdata(prot_wdata)
  );

  function automatic logic rts_next(logic cur, logic [7:0] t, logic [6:0] lvl);
    int halt_l = int'(t[3:0]) * 4;
    int res_l  = int'(t[7:4]) * 4;
    if (int'(lvl) >= halt_l) return 1'b1;
    if (int'(lvl) <= res_l)  return 1'b0;
    return cur;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 rts", rts_pin, 0);
    check("R1 tx_stop", tx_stop, 0);
    check("R1 flag", spchar_irq, 0);
    check("R1 prot_we", prot_we, 0);

    // R2 disabled RTS with a full FIFO
    rx_level = 7'd64; tick(); tick();
    check("R2 rts off", rts_pin, 0);

    // R3/R4/R5 directed: halt 32, resume 8
    wr(3'd1, 8'h28); wr(3'd0, 8'h40);
    rx_level = 7'd31; tick(); check("R3 below halt", rts_pin, 0);
    rx_level = 7'd32; tick(); check("R3 at halt", rts_pin, 1);
    rx_level = 7'd20; tick(); check("R5 hold high", rts_pin, 1);
    rx_level = 7'd9;  tick(); check("R5 hold near resume", rts_pin, 1);
    rx_level = 7'd8;  tick(); check("R4 at resume", rts_pin, 0);
    rx_level = 7'd31; tick(); check("R5 hold low", rts_pin, 0);
    // R3 halt wins over resume when misprogrammed (halt 16, resume 32)
    wr(3'd1, 8'h84);
    rx_level = 7'd20; tick(); check("R3 halt wins", rts_pin, 1);
    rx_level = 7'd0;  tick(); check("R4 below both", rts_pin, 0);

    // R3/R4/R5 random sweep with occasional threshold changes
    m_trig = 8'h84; m_rts = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      logic do_wr;
      logic [7:0] nt;
      do_wr = ($urandom_range(49, 0) == 0);
      nt = 8'($urandom);
      rx_level = 7'($urandom_range(64, 0));
      if (do_wr) begin host_wr = 1'b1; host_addr = 3'd1; host_wdata = nt; end
      tick();
      host_wr = 1'b0;
      m_rts = rts_next(m_rts, m_trig, rx_level);
      if (do_wr) m_trig = nt;
      check("R3/R4/R5 random rts", rts_pin, m_rts);
    end

    // R2 disable again
    wr(3'd1, 8'h11); rx_level = 7'd50; tick();
    check("R3 before disable", rts_pin, 1);
    wr(3'd0, 8'h00); tick();
    check("R2 disabled after write", rts_pin, 0);

    // R6/R7 CTS
    wr(3'd0, 8'h80);
    tx_char_boundary = 1'b0; cts_pin = 1'b1;
    repeat (5) tick();
    check("R7 no stop mid-frame", tx_stop, 0);
    tx_char_boundary = 1'b1; tick();
    check("R6 stop at boundary", tx_stop, 1);
    cts_pin = 1'b0; tx_char_boundary = 1'b0;
    tick(); tick();
    check("R7 sync delay on release", tx_stop, 1);
    tick();
    check("R7 release", tx_stop, 0);
    tx_char_boundary = 1'b1; cts_pin = 1'b1;
    tick(); tick();
    check("R6 two-flop latency", tx_stop, 0);
    tick();
    check("R6 stop third edge", tx_stop, 1);
    wr(3'd0, 8'h00); tick();
    check("R7 release on disable", tx_stop, 0);
    cts_pin = 1'b0; tx_char_boundary = 1'b0;

    // R8/R9 special character
    wr(3'd2, 8'h13); wr(3'd0, 8'h20);
    rx_byte = 8'h14; rx_valid = 1'b1; tick(); rx_valid = 1'b0;
    check("R8 mismatch", spchar_irq, 0);
    rx_byte = 8'h13; rx_valid = 1'b1; tick(); rx_valid = 1'b0;
    check("R8 match", spchar_irq, 1);
    repeat (3) tick();
    check("R9 sticky", spchar_irq, 1);
    host_iir_rd = 1'b1; tick(); host_iir_rd = 1'b0;
    check("R9 read clears", spchar_irq, 0);
    rx_valid = 1'b1; host_iir_rd = 1'b1; tick(); rx_valid = 1'b0; host_iir_rd = 1'b0;
    check("R9 set beats clear", spchar_irq, 1);
    host_iir_rd = 1'b1; tick(); host_iir_rd = 1'b0;
    wr(3'd0, 8'h00);
    rx_valid = 1'b1; tick(); rx_valid = 1'b0;
    check("R8 detect off", spchar_irq, 0);
    wr(3'd0, 8'h20);
    m_flag = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      rx_byte = 8'h10 + 8'($urandom_range(5, 0));
      rx_valid = $urandom_range(1, 0) == 1;
      host_iir_rd = $urandom_range(3, 0) == 0;
      tick();
      if (rx_valid && rx_byte == 8'h13) m_flag = 1'b1;
      else if (host_iir_rd) m_flag = 1'b0;
      check("R8/R9 random flag", spchar_irq, m_flag);
    end
    rx_valid = 1'b0; host_iir_rd = 1'b0;

    // R10 protected fields
    wr(3'd0, 8'h00);
    wr(3'd3, 8'hF0); check("R10 blocked IER", prot_we, 3'b000);
    wr(3'd5, 8'hE0); check("R10 blocked MCR", prot_we, 3'b000);
    wr(3'd0, 8'h10);
    wr(3'd4, 8'h30); check("R10 FCR strobe", prot_we, 3'b010);
    check("R10 FCR data", prot_wdata, 8'h30);
    tick();           check("R10 single pulse", prot_we, 3'b000);
    wr(3'd5, 8'hA0); check("R10 MCR strobe", prot_we, 3'b100);
    wr(3'd3, 8'h90); check("R10 IER strobe", prot_we, 3'b001);
    check("R10 IER data", prot_wdata, 8'h90);
    wr(3'd1, 8'h55); check("R10 other address", prot_we, 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule